// File: doc/BRIEF.md
# Mode-Dependent Eight-Pin Parallel Port

This block controls eight bidirectional pins through three registers on a small register bus. The registers hold a direction mask, an output data byte and a pull-up enable mask. When the port is in general mode, each pin is either a driven output or a sampled input, and input pins can have their pull-up turned on. When the port is in expanded-bus mode, the direction mask is ignored and the eight pins carry an external data bus. In that mode a bus output-enable chooses whether the pins drive the bus write data or pass the pad values back to the bus read path.

There are two standby inputs. Hardware standby clears the direction mask. Software standby keeps it, so any pin that was an output stays driven. In expanded-bus mode the bus stops driving during reset and during either standby. All register writes and the read data are synchronous to one clock, and reset is synchronous and active-high.

Top module: `gpio8_port`

## Requirements
- R1: A synchronous reset clears the direction, data and pull-up registers to 0. In the cycle after reset, no pin is driven and no pull-up is on.
- R2: The direction register is at 16'hFFB4. It can only be written. Reading its address returns 8'hFF whatever it holds.
- R3: The data register is at 16'hFFB6. Reading it returns, bit by bit, the latched data value for pins whose direction bit is 1 and the `pad_in` value for pins whose direction bit is 0.
- R4: The pull-up register is at 16'hFFAE. It can be written, and reading it returns the last value written.
- R5: In general mode (`ext_bus_mode`=0), `pad_oe[i]` equals direction bit i and `pad_out` equals the data register.
- R6: `pad_pu[i]` is 1 only when pull-up bit i is 1, direction bit i is 0 and the port is in general mode.
- R7: In expanded-bus mode, the direction register has no effect. `pad_out` follows `bus_wdata`, all `pad_oe` bits follow `bus_oe`, and `bus_rdata` follows `pad_in`. In general mode, `bus_rdata` is 0.
- R8: In expanded-bus mode, all `pad_oe` bits are 0 while `rst`, `hw_stby` or `sw_stby` is high.
- R9: At each clock edge where `hw_stby` is high, the direction register is cleared. A direction write in that same cycle is lost. Hardware standby does not change the data or pull-up registers.
- R10: Software standby leaves all registers unchanged. General-mode output pins keep being driven during software standby.
- R11: A write changes a register only when `reg_wr` is high and `reg_addr` matches that register. Writes to any other address, and address values without `reg_wr`, change nothing.
- R12: `reg_rdata` is registered. It shows the read value in the cycle after a clock edge with `reg_rd` high. It is 0 after an edge without `reg_rd`, and 0 after a read of an unmapped address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_bus_mode | input | 1 | 1 selects expanded-bus mode, 0 selects general mode |
| hw_stby | input | 1 | Hardware standby |
| sw_stby | input | 1 | Software standby |
| reg_addr | input | 16 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| bus_wdata | input | 8 | External bus write data (expanded mode) |
| bus_oe | input | 1 | External bus drive request (expanded mode) |
| bus_rdata | output | 8 | Pad values passed to the external bus |
| pad_in | input | 8 | Sampled pin values |
| pad_out | output | 8 | Pin output values |
| pad_oe | output | 8 | Pin output enables |
| pad_pu | output | 8 | Pin pull-up enables |

## Verification
The direction mask is set to the mixed pattern A5 while `pad_in` takes several different values. This shows whether each data-register readback bit comes from the latch or from the pad, and whether the pull-ups follow the inverted direction mask. Writes to an unmapped address and address values sent without a strobe show whether the decode is gated by both strobe and address. Standby pulses are applied with a populated direction mask, both in general mode and in expanded-bus mode. They tell hardware standby (clears the mask) apart from software standby (keeps the mask and the drive), and they check that the bus stops driving in expanded mode. Pulling `bus_oe` high and low in expanded mode with the mask non-zero shows that the mask has no effect there.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_DAT  = 2'd2,
    SEL_PUL  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio8_regs.sv
module gpio8_regs
  import gpio8_pkg::*;
#(
  parameter int W = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] DIR_ADDR = 16'hFFB4,
  parameter logic [AW-1:0] DAT_ADDR = 16'hFFB6,
  parameter logic [AW-1:0] PUL_ADDR = 16'hFFAE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hw_stby,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  rdata,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  dat_q,
  output logic [W-1:0]  pul_q
);
  reg_sel_e sel;
  logic [W-1:0] dat_view;

  always_comb begin
    if (addr == DIR_ADDR)      sel = SEL_DIR;
    else if (addr == DAT_ADDR) sel = SEL_DAT;
    else if (addr == PUL_ADDR) sel = SEL_PUL;
    else                       sel = SEL_NONE;
  end

  // output pins show the latch, input pins show the pad
  assign dat_view = (dat_q & dir_q) | (pad_in & ~dir_q);

  always_ff @(posedge clk) begin
    if (rst || hw_stby)               dir_q <= '0;
    else if (wr && sel == SEL_DIR)    dir_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dat_q <= '0;
      pul_q <= '0;
    end else begin
      if (wr && sel == SEL_DAT) dat_q <= wdata;
      if (wr && sel == SEL_PUL) pul_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !rd) rdata <= '0;
    else begin
      case (sel)
        SEL_DIR: rdata <= '1;
        SEL_DAT: rdata <= dat_view;
        SEL_PUL: rdata <= pul_q;
        default: rdata <= '0;
      endcase
    end
  end

  a_r2_dir_reads_ones: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == DIR_ADDR) |=> (rdata == {W{1'b1}}));

  a_r9_hw_clears_dir: assert property (@(posedge clk) disable iff (rst)
    hw_stby |=> (dir_q == '0));

  a_r10_r11_no_stray_write: assert property (@(posedge clk) disable iff (rst)
    (!hw_stby && !(wr && (addr == DIR_ADDR || addr == DAT_ADDR || addr == PUL_ADDR)))
      |=> ($stable(dir_q) && $stable(dat_q) && $stable(pul_q)));

  a_r12_idle_read_zero: assert property (@(posedge clk) disable iff (rst)
    !rd |=> (rdata == '0));
endmodule

// File: rtl/gpio8_pads.sv
module gpio8_pads #(
  parameter int W = 8
) (
  input  logic         ext_bus_mode,
  input  logic         quiet,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] dat_q,
  input  logic [W-1:0] pul_q,
  input  logic [W-1:0] bus_wdata,
  input  logic         bus_oe,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] bus_rdata,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pad_out[i]   = ext_bus_mode ? bus_wdata[i] : dat_q[i];
    assign pad_oe[i]    = ext_bus_mode ? (bus_oe & ~quiet) : dir_q[i];
    assign pad_pu[i]    = ~ext_bus_mode & pul_q[i] & ~dir_q[i];
    assign bus_rdata[i] = ext_bus_mode & pad_in[i];
  end

  always_comb begin
    a_r6_pullup_only_on_inputs: assert ((pad_pu & pad_oe) == '0);
  end
endmodule

// File: rtl/gpio8_port.sv
module gpio8_port #(
  parameter int W = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] DIR_ADDR = 16'hFFB4,
  parameter logic [AW-1:0] DAT_ADDR = 16'hFFB6,
  parameter logic [AW-1:0] PUL_ADDR = 16'hFFAE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ext_bus_mode,
  input  logic          hw_stby,
  input  logic          sw_stby,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic [W-1:0]  bus_wdata,
  input  logic          bus_oe,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_pu
);
  logic [W-1:0] dir_q, dat_q, pul_q;
  logic quiet;

  assign quiet = rst | hw_stby | sw_stby;

  gpio8_regs #(.W(W), .AW(AW), .DIR_ADDR(DIR_ADDR), .DAT_ADDR(DAT_ADDR),
               .PUL_ADDR(PUL_ADDR)) u_regs (
    .clk(clk), .rst(rst), .hw_stby(hw_stby), .addr(reg_addr), .wr(reg_wr),
    .rd(reg_rd), .wdata(reg_wdata), .pad_in(pad_in), .rdata(reg_rdata),
    .dir_q(dir_q), .dat_q(dat_q), .pul_q(pul_q)
  );

  gpio8_pads #(.W(W)) u_pads (
    .ext_bus_mode(ext_bus_mode), .quiet(quiet), .dir_q(dir_q), .dat_q(dat_q),
    .pul_q(pul_q), .bus_wdata(bus_wdata), .bus_oe(bus_oe), .pad_in(pad_in),
    .bus_rdata(bus_rdata), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  a_r8_bus_quiet: assert property (@(posedge clk) disable iff (rst)
    (ext_bus_mode && (hw_stby || sw_stby)) |-> (pad_oe == '0));

  a_r10_sw_keeps_drive: assert property (@(posedge clk) disable iff (rst)
    (!ext_bus_mode && $past(!ext_bus_mode) && sw_stby && $past(sw_stby)
     && !$past(hw_stby) && !$past(reg_wr)) |-> $stable(pad_oe));
endmodule

// File: tb/sim_gpio8_port.sv
module sim_gpio8_port;
  logic clk = 0, rst = 1, ext_bus_mode = 0, hw_stby = 0, sw_stby = 0;
  logic [15:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0, bus_oe = 0;
  logic [7:0] reg_wdata = 0, bus_wdata = 0, pad_in = 0;
  logic [7:0] reg_rdata, bus_rdata, pad_out, pad_oe, pad_pu;

  localparam logic [15:0] A_DIR = 16'hFFB4, A_DAT = 16'hFFB6, A_PUL = 16'hFFAE;

  gpio8_port u0 (.*);

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] m_dir = 0, m_dat = 0, m_pul = 0, m_rd = 0;
  string rd_tag = "R1";

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] e_oe, e_out, e_pu, e_brd;
    string oe_tag;
    if (ext_bus_mode) begin
      e_out = bus_wdata; e_pu = 0; e_brd = pad_in;
      e_oe = (bus_oe && !rst && !hw_stby && !sw_stby) ? 8'hFF : 8'h00;
      oe_tag = (rst || hw_stby || sw_stby) ? "R8" : "R7";
    end else begin
      e_out = m_dat; e_oe = m_dir; e_pu = m_pul & ~m_dir; e_brd = 0;
      oe_tag = sw_stby ? "R10" : (hw_stby ? "R9" : "R5");
    end
    chk(oe_tag, pad_oe, e_oe);
    chk(ext_bus_mode ? "R7" : "R5", pad_out, e_out);
    chk("R6", pad_pu, e_pu);
    chk("R7", bus_rdata, e_brd);
    chk(rd_tag, reg_rdata, m_rd);
  endtask

  task automatic step();
    @(posedge clk);
    if (rst) begin
      m_rd = 0; rd_tag = "R1";
    end else if (reg_rd) begin
      case (reg_addr)
        A_DIR: begin m_rd = 8'hFF; rd_tag = "R2"; end
        A_DAT: begin m_rd = (m_dat & m_dir) | (pad_in & ~m_dir); rd_tag = "R3"; end
        A_PUL: begin m_rd = m_pul; rd_tag = "R4"; end
        default: begin m_rd = 0; rd_tag = "R12"; end
      endcase
    end else begin
      m_rd = 0; rd_tag = "R12";
    end
    if (rst || hw_stby) m_dir = 0;
    else if (reg_wr && reg_addr == A_DIR) m_dir = reg_wdata;
    if (rst) begin m_dat = 0; m_pul = 0; end
    else begin
      if (reg_wr && reg_addr == A_DAT) m_dat = reg_wdata;
      if (reg_wr && reg_addr == A_PUL) m_pul = reg_wdata;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1; step(); reg_wr = 0;
  endtask

  task automatic rd(logic [15:0] a);
    reg_addr = a; reg_rd = 1; step(); reg_rd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(); step();
    rst = 0;
    step();
    chk("R1", pad_oe, 8'h00);
    chk("R1", pad_pu, 8'h00);
    rd(A_DAT);
    chk("R1", reg_rdata, 8'h00);
    // R5 / R3 / R4 / R6
    wr(A_DIR, 8'hA5);
    wr(A_DAT, 8'h3C);
    wr(A_PUL, 8'hFF);
    chk("R5", pad_oe, 8'hA5);
    chk("R6", pad_pu, 8'h5A);
    rd(A_DIR);
    chk("R2", reg_rdata, 8'hFF);
    pad_in = 8'h0F; rd(A_DAT);
    chk("R3", reg_rdata, 8'h2E);
    pad_in = 8'hF0; rd(A_DAT);
    chk("R3", reg_rdata, 8'h74);
    rd(A_PUL);
    chk("R4", reg_rdata, 8'hFF);
    step();
    chk("R12", reg_rdata, 8'h00);
    rd(16'h1234);
    chk("R12", reg_rdata, 8'h00);
    // R11 stray writes
    wr(16'h1234, 8'h00);
    reg_addr = A_DIR; reg_wdata = 8'h00; step();
    chk("R11", pad_oe, 8'hA5);
    rd(A_PUL);
    chk("R11", reg_rdata, 8'hFF);
    // R10 software standby
    sw_stby = 1;
    repeat (3) step();
    chk("R10", pad_oe, 8'hA5);
    chk("R10", pad_out, 8'h3C);
    sw_stby = 0; step();
    // R9 hardware standby, write lost
    hw_stby = 1; reg_addr = A_DIR; reg_wdata = 8'hFF; reg_wr = 1; step();
    reg_wr = 0; step();
    chk("R9", pad_oe, 8'h00);
    hw_stby = 0;
    rd(A_PUL);
    chk("R9", reg_rdata, 8'hFF);
    wr(A_DIR, 8'h0F);
    // R7 expanded bus
    ext_bus_mode = 1; bus_wdata = 8'h96; bus_oe = 1; pad_in = 8'h3A; step();
    chk("R7", pad_oe, 8'hFF);
    chk("R7", pad_out, 8'h96);
    chk("R7", bus_rdata, 8'h3A);
    bus_oe = 0; step();
    chk("R7", pad_oe, 8'h00);
    bus_oe = 1;
    // R8 quiet during standby and reset
    sw_stby = 1; step();
    chk("R8", pad_oe, 8'h00);
    sw_stby = 0; hw_stby = 1; step();
    chk("R8", pad_oe, 8'h00);
    hw_stby = 0; step();
    rst = 1; #1;
    chk("R8", pad_oe, 8'h00);
    step();
    rst = 0; ext_bus_mode = 0; step();
    chk("R1", pad_oe, 8'h00);
    for (int k = 0; k < 8; k++) begin
      pad_in = 8'h11 * k[7:0];
      wr(A_DIR, 8'h01 << k);
      rd(A_DAT);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule